// File: doc/BRIEF.md
# PS/2 Wake and Isolation Controller

This block sits between the keyboard and mouse connector lines and an on-chip legacy keyboard controller. It passes the clock and data lines through to that controller. Per-port isolation bits can block them, with the blocked lines held at the idle-high level. It also shapes the controller's two interrupt outputs through a latch. Each interrupt can be presented either as the latched copy alone or as the raw line ANDed with the latched copy.

For system wake, the block records four power-management events in sticky status bits:
- a keyboard interrupt;
- a mouse interrupt;
- a falling edge on the keyboard data line;
- a falling edge on the mouse data line.

A wake output rises when a recorded event has its enable bit set and the global enable is on. Interrupt events count only while main power is good. Data-edge events also count under standby power, and the isolation gating never affects them. A separate non-self-clearing bit holds the keyboard controller in reset.

Software reaches the block through a single-cycle write port with a 2-bit address. Read-side visibility comes from the status, wake and reset outputs.

Top module: `ps2w_top`

## Requirements
- R1: After reset the status bits are 0, `wake_out` is 0, `kbc_rst` is 0, and both interrupt outputs are 0. All control bits are 0: no isolation and both latch modes 0.
- R2: The control register is at address 0. When bit 5 is 1, the keyboard clock and data towards the controller are forced to 1. When bit 6 is 1, the mouse clock and data towards the controller are forced to 1. When a bit is 0, that port's pin levels pass through unchanged.
- R3: Control bit 3 sets the keyboard interrupt latch mode, and bit 4 sets the mouse mode. In mode 0 the interrupt output is the raw controller interrupt AND the latch. In mode 1 it is the latch alone.
- R4: A latch sets on a rising edge of its raw interrupt and clears on a cycle with its read-clear pulse. If a rising edge and a clear pulse occur in the same cycle, the latch sets.
- R5: A rising edge of the raw keyboard interrupt sets status bit 0, and a rising edge of the raw mouse interrupt sets status bit 1. Each does so only when `main_pwr_ok` is 1 at that edge.
- R6: A falling edge on keyboard data sets status bit 2, and a falling edge on mouse data sets status bit 3. Each data input first passes through a two-flop synchronizer, so the status bit is visible three clock edges after the pin falls. Detection works whatever the level of `main_pwr_ok` and whatever the isolation bits.
- R7: Status is at address 1 and its bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an event and a clear of the same bit occur in the same cycle, the bit is set.
- R8: Address 2 holds the per-event wake enables in bits 3:0, matching the status bit order, and the global enable in bit 7. `wake_out` is 1 exactly when the global enable is 1 and some status bit is 1 with its enable also 1.
- R9: Bit 6 at address 3 drives `kbc_rst`. It stays 1 until software writes a 0 to that bit.
- R10: A rising edge on a data line sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_pwr_ok | input | 1 | Main power good; 0 means standby only |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| kb_clk_pin | input | 1 | Keyboard clock line from connector |
| kb_dat_pin | input | 1 | Keyboard data line from connector |
| ms_clk_pin | input | 1 | Mouse clock line from connector |
| ms_dat_pin | input | 1 | Mouse data line from connector |
| kbc_kb_clk | output | 1 | Keyboard clock towards controller |
| kbc_kb_dat | output | 1 | Keyboard data towards controller |
| kbc_ms_clk | output | 1 | Mouse clock towards controller |
| kbc_ms_dat | output | 1 | Mouse data towards controller |
| kbc_kb_irq | input | 1 | Raw keyboard interrupt from controller |
| kbc_ms_irq | input | 1 | Raw mouse interrupt from controller |
| kb_obf_rd | input | 1 | Keyboard output-buffer read pulse (clears latch) |
| ms_obf_rd | input | 1 | Mouse output-buffer read pulse (clears latch) |
| kb_irq_out | output | 1 | Conditioned keyboard interrupt |
| ms_irq_out | output | 1 | Conditioned mouse interrupt |
| pme_sts | output | 4 | Event status bits |
| wake_out | output | 1 | Wake request |
| kbc_rst | output | 1 | Keyboard controller reset |

## Verification
A latch stuck in the wrong state shows in the next cycle on the interrupt output in mode 1. In mode 0 it shows as soon as the raw line is high. A synchronizer that is too short or too long moves the status bit off its third-edge slot, and the bench samples that exact cycle. A status bit that drops or appears without cause shows on `pme_sts` and, once its enables are on, on `wake_out` in the same cycle. A gating error shows at once on the controller-side lines.

// File: rtl/ps2w_pkg.sv
package ps2w_pkg;
  localparam int NCH   = 2;        // channel 0 keyboard, channel 1 mouse
  localparam int NEVT  = 2 * NCH;  // irq events then data-edge events
  localparam int RW    = 8;
  localparam int AW    = 2;

  typedef enum logic [AW-1:0] {
    ADR_CTRL = 2'd0,
    ADR_STS  = 2'd1,
    ADR_WEN  = 2'd2,
    ADR_KRST = 2'd3
  } reg_addr_e;

  localparam int B_KB_LMODE = 3;
  localparam int B_MS_LMODE = 4;
  localparam int B_KB_ISO   = 5;
  localparam int B_MS_ISO   = 6;
  localparam int B_GEN      = 7;
  localparam int B_KRST     = 6;

  // Interrupt presentation for one channel.
  function automatic logic irq_view(input logic mode, input logic raw, input logic lat);
    return mode ? lat : (raw & lat);
  endfunction

  // Wake request from status, per-event enables and global enable.
  function automatic logic wake_eval(input logic [NEVT-1:0] sts,
                                     input logic [NEVT-1:0] en,
                                     input logic            gen);
    return gen & (|(sts & en));
  endfunction

  // Line seen by the controller: idle high while isolated.
  function automatic logic iso_gate(input logic iso, input logic pin);
    return iso ? 1'b1 : pin;
  endfunction
endpackage

// File: rtl/ps2w_fall_det.sv
module ps2w_fall_det #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= {STAGES{IDLE}};
      last_q <= IDLE;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/ps2w_irq_latch.sv
module ps2w_irq_latch
  import ps2w_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic rd_clr,
  input  logic mode,
  input  logic pwr_ok,
  output logic irq_o,
  output logic lat_o,
  output logic evt_o
);
  logic raw_d;
  logic lat_q;
  logic rise;

  assign rise = raw & ~raw_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_d <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      raw_d <= raw;
      if (rise)        lat_q <= 1'b1;
      else if (rd_clr) lat_q <= 1'b0;
    end
  end

  assign irq_o = irq_view(mode, raw, lat_q);
  assign lat_o = lat_q;
  assign evt_o = rise & pwr_ok;
endmodule

// File: rtl/ps2w_regs.sv
module ps2w_regs
  import ps2w_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [RW-1:0]   wdata,
  input  logic [NEVT-1:0] evt,
  output logic [NCH-1:0]  iso,
  output logic [NCH-1:0]  lmode,
  output logic [NEVT-1:0] sts,
  output logic [NEVT-1:0] wen,
  output logic            gen,
  output logic            krst
);
  logic [NCH-1:0]  iso_q, lmode_q;
  logic [NEVT-1:0] sts_q, wen_q, clr;
  logic            gen_q, krst_q;
  logic            wr_ctrl, wr_sts, wr_wen, wr_krst;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_sts  = wr && (addr == ADR_STS);
  assign wr_wen  = wr && (addr == ADR_WEN);
  assign wr_krst = wr && (addr == ADR_KRST);
  assign clr     = wr_sts ? wdata[NEVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iso_q   <= '0;
      lmode_q <= '0;
      sts_q   <= '0;
      wen_q   <= '0;
      gen_q   <= 1'b0;
      krst_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        iso_q   <= {wdata[B_MS_ISO], wdata[B_KB_ISO]};
        lmode_q <= {wdata[B_MS_LMODE], wdata[B_KB_LMODE]};
      end
      if (wr_wen) begin
        wen_q <= wdata[NEVT-1:0];
        gen_q <= wdata[B_GEN];
      end
      if (wr_krst) krst_q <= wdata[B_KRST];
      sts_q <= (sts_q & ~clr) | evt;
    end
  end

  assign iso   = iso_q;
  assign lmode = lmode_q;
  assign sts   = sts_q;
  assign wen   = wen_q;
  assign gen   = gen_q;
  assign krst  = krst_q;
endmodule

// File: rtl/ps2w_top.sv
module ps2w_top
  import ps2w_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        main_pwr_ok,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        kb_clk_pin,
  input  logic        kb_dat_pin,
  input  logic        ms_clk_pin,
  input  logic        ms_dat_pin,
  output logic        kbc_kb_clk,
  output logic        kbc_kb_dat,
  output logic        kbc_ms_clk,
  output logic        kbc_ms_dat,
  input  logic        kbc_kb_irq,
  input  logic        kbc_ms_irq,
  input  logic        kb_obf_rd,
  input  logic        ms_obf_rd,
  output logic        kb_irq_out,
  output logic        ms_irq_out,
  output logic [3:0]  pme_sts,
  output logic        wake_out,
  output logic        kbc_rst
);
  // Named internal events, also observed by the bound checker.
  logic [NCH-1:0]  iso, lmode, lat, irq_evt, dat_fall, irq_o;
  logic [NCH-1:0]  pin_clk, pin_dat, raw_irq, rd_clr, gclk, gdat;
  logic [NEVT-1:0] sts, wen, evt;
  logic            gen;

  assign pin_clk = {ms_clk_pin, kb_clk_pin};
  assign pin_dat = {ms_dat_pin, kb_dat_pin};
  assign raw_irq = {kbc_ms_irq, kbc_kb_irq};
  assign rd_clr  = {ms_obf_rd, kb_obf_rd};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ps2w_fall_det #(.STAGES(2), .IDLE(1'b1)) u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_dat[c]),
      .fall (dat_fall[c])
    );

    ps2w_irq_latch u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_irq[c]),
      .rd_clr(rd_clr[c]),
      .mode  (lmode[c]),
      .pwr_ok(main_pwr_ok),
      .irq_o (irq_o[c]),
      .lat_o (lat[c]),
      .evt_o (irq_evt[c])
    );

    assign gclk[c] = iso_gate(iso[c], pin_clk[c]);
    assign gdat[c] = iso_gate(iso[c], pin_dat[c]);
  end

  assign evt = {dat_fall, irq_evt};

  ps2w_regs u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (reg_wr),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .evt  (evt),
    .iso  (iso),
    .lmode(lmode),
    .sts  (sts),
    .wen  (wen),
    .gen  (gen),
    .krst (kbc_rst)
  );

  assign kbc_kb_clk = gclk[0];
  assign kbc_kb_dat = gdat[0];
  assign kbc_ms_clk = gclk[1];
  assign kbc_ms_dat = gdat[1];
  assign kb_irq_out = irq_o[0];
  assign ms_irq_out = irq_o[1];
  assign pme_sts    = sts;
  assign wake_out   = wake_eval(sts, wen, gen);
endmodule

// File: rtl/ps2w_checker.sv
module ps2w_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       main_pwr_ok,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       kbc_kb_irq,
  input logic       kbc_ms_irq,
  input logic       kbc_kb_clk,
  input logic       kbc_kb_dat,
  input logic       kbc_ms_clk,
  input logic       kbc_ms_dat,
  input logic       kb_irq_out,
  input logic       ms_irq_out,
  input logic [3:0] pme_sts,
  input logic       wake_out,
  input logic       kbc_rst,
  input logic [1:0] iso,
  input logic [1:0] lat,
  input logic [1:0] dat_fall,
  input logic [3:0] wen,
  input logic       gen
);
  a_r2_kb_iso_high: assert property (@(posedge clk) disable iff (!rst_n)
    iso[0] |-> (kbc_kb_clk && kbc_kb_dat));
  a_r2_ms_iso_high: assert property (@(posedge clk) disable iff (!rst_n)
    iso[1] |-> (kbc_ms_clk && kbc_ms_dat));
  a_r3_kb_no_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lat[0] |-> !kb_irq_out);
  a_r3_ms_no_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lat[1] |-> !ms_irq_out);
  a_r4_kb_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbc_kb_irq) |=> lat[0]);
  a_r4_ms_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbc_ms_irq) |=> lat[1]);
  a_r5_standby_no_irq_evt: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pwr_ok |=> ((pme_sts[1:0] & ~$past(pme_sts[1:0])) == 2'b00));
  a_r6_kb_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dat_fall[0] |=> pme_sts[2]);
  a_r6_ms_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dat_fall[1] |=> pme_sts[3]);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=> ((pme_sts & $past(pme_sts)) == $past(pme_sts)));
  a_r8_wake_needs_gen: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> !wake_out);
  a_r8_wake_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
    ((pme_sts & wen) == 4'd0) |-> !wake_out);
  a_r9_krst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kbc_rst && !(reg_wr && reg_addr == 2'd3)) |=> kbc_rst);
endmodule

bind ps2w_top ps2w_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .main_pwr_ok(main_pwr_ok),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .kbc_kb_irq (kbc_kb_irq),
  .kbc_ms_irq (kbc_ms_irq),
  .kbc_kb_clk (kbc_kb_clk),
  .kbc_kb_dat (kbc_kb_dat),
  .kbc_ms_clk (kbc_ms_clk),
  .kbc_ms_dat (kbc_ms_dat),
  .kb_irq_out (kb_irq_out),
  .ms_irq_out (ms_irq_out),
  .pme_sts    (pme_sts),
  .wake_out   (wake_out),
  .kbc_rst    (kbc_rst),
  .iso        (iso),
  .lat        (lat),
  .dat_fall   (dat_fall),
  .wen        (wen),
  .gen        (gen)
);

// File: tb/tb_ps2w_top.sv
module tb_ps2w_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_pwr_ok = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       kb_clk_pin = 1'b1, kb_dat_pin = 1'b1, ms_clk_pin = 1'b1, ms_dat_pin = 1'b1;
  logic       kbc_kb_clk, kbc_kb_dat, kbc_ms_clk, kbc_ms_dat;
  logic       kbc_kb_irq = 1'b0, kbc_ms_irq = 1'b0, kb_obf_rd = 1'b0, ms_obf_rd = 1'b0;
  logic       kb_irq_out, ms_irq_out, wake_out, kbc_rst;
  logic [3:0] pme_sts;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  ps2w_top dut (.*);

  // {ms_iso, kb_iso, kclk, kdat, mclk, mdat, expected controller-side 4 bits}
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 4'b0101, 4'b0101},
    {2'b00, 4'b1010, 4'b1010},
    {2'b01, 4'b0000, 4'b1100},
    {2'b10, 4'b0000, 4'b0011},
    {2'b11, 4'b0000, 4'b1111},
    {2'b01, 4'b0011, 4'b1111},
    {2'b10, 4'b1100, 4'b1111},
    {2'b11, 4'b1010, 4'b1111}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 sts", {4'd0, pme_sts}, 8'h00);
    check("R1 wake/rst/irq", {4'd0, wake_out, kbc_rst, kb_irq_out, ms_irq_out}, 8'h00);
    check("R1 passthrough", {4'd0, kbc_kb_clk, kbc_kb_dat, kbc_ms_clk, kbc_ms_dat}, 8'h0F);

    // R2 isolation table
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {1'b0, VEC[i][9], VEC[i][8], 5'b0});
      {kb_clk_pin, kb_dat_pin, ms_clk_pin, ms_dat_pin} = VEC[i][7:4];
      #1;
      check("R2 gating", {4'd0, kbc_kb_clk, kbc_kb_dat, kbc_ms_clk, kbc_ms_dat}, {4'd0, VEC[i][3:0]});
    end
    {kb_clk_pin, kb_dat_pin, ms_clk_pin, ms_dat_pin} = 4'hF;
    cyc(4);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0F);
    check("R7 clear all", {4'd0, pme_sts}, 8'h00);

    // R3/R4/R5 keyboard interrupt, mode 0
    kbc_kb_irq = 1'b1;
    cyc(1);
    check("R3 mode0 raw&latch", {7'd0, kb_irq_out}, 8'h01);
    check("R5 kb irq sts", {4'd0, pme_sts}, 8'h01);
    kb_obf_rd = 1'b1; cyc(1); kb_obf_rd = 1'b0;
    check("R4 clear pulse", {7'd0, kb_irq_out}, 8'h00);
    kbc_kb_irq = 1'b0; cyc(1);
    kbc_kb_irq = 1'b1; cyc(1);
    wr(2'd0, 8'h08);  // keyboard mode 1
    kbc_kb_irq = 1'b0; cyc(1);
    check("R3 mode1 latch only", {7'd0, kb_irq_out}, 8'h01);
    kb_obf_rd = 1'b1; cyc(1); kb_obf_rd = 1'b0;
    check("R4 mode1 cleared", {7'd0, kb_irq_out}, 8'h00);
    kbc_kb_irq = 1'b1; kb_obf_rd = 1'b1; cyc(1); kb_obf_rd = 1'b0;
    check("R4 set wins over clear", {7'd0, kb_irq_out}, 8'h01);
    kbc_kb_irq = 1'b0;
    wr(2'd0, 8'h00);
    check("R3 mode0 raw low", {7'd0, kb_irq_out}, 8'h00);

    // R5 mouse interrupt under standby then main power
    main_pwr_ok = 1'b0;
    kbc_ms_irq = 1'b1; cyc(2);
    check("R5 standby no irq sts", {4'd0, pme_sts}, 8'h01);
    kbc_ms_irq = 1'b0; cyc(1);
    main_pwr_ok = 1'b1;
    kbc_ms_irq = 1'b1; cyc(1);
    check("R5 ms irq sts", {4'd0, pme_sts}, 8'h03);
    kbc_ms_irq = 1'b0;

    // R8 wake combinations, status = 0011
    wr(2'd2, 8'h01);
    check("R8 global off", {7'd0, wake_out}, 8'h00);
    wr(2'd2, 8'h81);
    check("R8 enabled match", {7'd0, wake_out}, 8'h01);
    wr(2'd2, 8'h84);
    check("R8 enabled no match", {7'd0, wake_out}, 8'h00);
    wr(2'd2, 8'h82);
    check("R8 mouse match", {7'd0, wake_out}, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h0F);

    // R6/R10 mouse data edge under standby with isolation
    main_pwr_ok = 1'b0;
    wr(2'd0, 8'h40);
    ms_dat_pin = 1'b0;
    cyc(2);
    check("R6 not before third edge", {4'd0, pme_sts}, 8'h00);
    cyc(1);
    check("R6 ms edge sts", {4'd0, pme_sts}, 8'h08);
    check("R2 ms still isolated", {7'd0, kbc_ms_dat}, 8'h01);
    wr(2'd1, 8'h08);
    check("R7 w1c bit3", {4'd0, pme_sts}, 8'h00);
    ms_dat_pin = 1'b1;
    cyc(5);
    check("R10 rising no sts", {4'd0, pme_sts}, 8'h00);
    wr(2'd0, 8'h00);
    main_pwr_ok = 1'b1;

    // R7 set wins over simultaneous clear
    @(negedge clk);
    kbc_kb_irq = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R7 set beats clear", {4'd0, pme_sts}, 8'h01);
    kb_dat_pin = 1'b0; cyc(3);
    check("R6 kb edge sts", {4'd0, pme_sts}, 8'h05);
    wr(2'd1, 8'h04);
    check("R7 selective clear", {4'd0, pme_sts}, 8'h01);
    kb_dat_pin = 1'b1; kbc_kb_irq = 1'b0;

    // R9 controller reset bit
    wr(2'd3, 8'h40);
    check("R9 set", {7'd0, kbc_rst}, 8'h01);
    cyc(6);
    check("R9 holds", {7'd0, kbc_rst}, 8'h01);
    wr(2'd3, 8'hBF);
    check("R9 cleared by zero", {7'd0, kbc_rst}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule